// File: doc/BRIEF.md
# Multi-Mode Program Fetch Controller

This block serves fetch-packet requests from a processor's instruction side using one on-chip storage array of 64 packets of 256 bits. A two-bit mode input decides how that array is used. In mapped mode the array is plain program RAM that appears in an address window, with one of two window bases chosen by a select input. In the three cache modes the array is a direct-mapped instruction cache with a tag and a valid bit per line. Enable mode fills lines on a miss. Freeze mode serves hits but does not allocate on a miss. Bypass mode sends every fetch to external memory and leaves the cache untouched.

A fetch is accepted on a rising edge where `fetch_req` is high and `fetch_stall` is low. A mapped fetch or a cache hit returns `fetch_valid` with its data one cycle later. A miss or a bypassed fetch raises `fetch_stall` and drives a request/acknowledge read on the external port. The packet is returned to the processor in the cycle after acknowledge and, in enable mode only, written into the array. The only event that invalidates the cache is a move from mapped mode into enable mode.

The controller has three states. In ST_IDLE it accepts fetches and samples the mode. ST_FILL is an allocating external read, entered from ST_IDLE on an enable-mode miss. ST_PASS is a non-allocating external read, entered from ST_IDLE on a freeze-mode miss or on any bypass fetch. Both ST_FILL and ST_PASS return to ST_IDLE on acknowledge. A mapped fetch or a hit keeps the controller in ST_IDLE.

Top module: `pfc_top`

## Requirements
- R1: After reset the controller is in mapped mode, every valid bit is clear, and `fetch_valid`, `fetch_stall` and `ext_req` are low.
- R2: In mapped mode, a fetch inside the window returns the array line numbered (address − base) / 32 one cycle after acceptance, with no stall and no external read.
- R3: `map_sel` = 0 places the window at `MAP_BASE0` and `map_sel` = 1 places it at `MAP_BASE1`. The window spans 2048 bytes. A mapped fetch outside the window returns all zeros after one cycle, with no external read.
- R4: A move from mapped (00) to enable (01) invalidates every line, so the next fetch to a previously filled line misses.
- R5: An enable-mode miss raises `fetch_stall` and `ext_req`. The request carries the packet address with its low five bits zero and holds it stable until `ext_ack`. `fetch_data` equals the acknowledged `ext_data` in the following cycle.
- R6: In enable mode, a fetch to a valid line with a matching tag returns the stored packet one cycle after acceptance, with no stall and no external read. The index is address bits [10:5] and the tag is bits [31:11].
- R7: In freeze mode (10) hits behave as in R6. A miss is read externally and forwarded but not written into the array, so a conflicting resident line survives and a repeated miss goes external again.
- R8: In bypass mode (11) every fetch, hit or not, is read externally, and the cache contents and valid bits are left unchanged.
- R9: The mode is encoded 00 mapped, 01 enable, 10 freeze, 11 bypass. It is sampled on each edge where no external read is outstanding. A change presented during an outstanding read applies only after that read completes, and the read finishes under the mode in which it began.
- R10: Moves from bypass or freeze into enable do not invalidate the cache.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_in | input | 2 | Requested operating mode (00 mapped, 01 enable, 10 freeze, 11 bypass) |
| map_sel | input | 1 | Window base select for mapped mode |
| fetch_req | input | 1 | Fetch request from the processor |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_stall | output | 1 | High while an external read is outstanding |
| fetch_valid | output | 1 | One-cycle pulse that marks returned fetch data |
| fetch_data | output | 256 | Returned fetch packet |
| ext_req | output | 1 | External read request |
| ext_addr | output | 32 | Packet-aligned external read address |
| ext_ack | input | 1 | External read acknowledge; data is valid in this cycle |
| ext_data | input | 256 | External read data |

## Verification
Two events can fall into the same cycle: a mode change and an external read that is still outstanding. They interact through the allocation decision and the flush. The bench starts an enable-mode miss with a long external latency and switches `mode_in` to bypass while the read is pending. It then checks three things: the forwarded data is correct, the next fetch to the same address goes external under bypass, and after a return to enable that address hits with the packet from the deferred fill. Together these show the read completed and allocated under its original mode. A second case places an accepted fetch on the same edge as a mapped-to-enable mode switch. The fetch is still served from the window, and the flush becomes visible only on the following fetch.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

    typedef enum logic [1:0] {
        MODE_MAPPED = 2'b00,
        MODE_ENABLE = 2'b01,
        MODE_FREEZE = 2'b10,
        MODE_BYPASS = 2'b11
    } pfc_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_FILL = 2'b01,
        ST_PASS = 2'b10
    } pfc_state_e;

endpackage

// File: rtl/pfc_map_window.sv
module pfc_map_window #(
    parameter int              ADDR_W = 32,
    parameter int              OFF_W  = 5,
    parameter int              IDX_W  = 6,
    parameter logic [ADDR_W-1:0] BASE0 = '0,
    parameter logic [ADDR_W-1:0] BASE1 = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              map_sel,
    output logic              in_win,
    output logic [IDX_W-1:0]  win_idx
);
    localparam int WIN_BYTES = (1 << IDX_W) << OFF_W;

    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] diff;

    always_comb begin
        base    = map_sel ? BASE1 : BASE0;
        diff    = addr - base;
        in_win  = (addr >= base) && (diff < ADDR_W'(WIN_BYTES));
        win_idx = diff[OFF_W +: IDX_W];
    end

endmodule

// File: rtl/pfc_tag_store.sv
module pfc_tag_store #(
    parameter int LINES = 64,
    parameter int IDX_W = 6,
    parameter int TAG_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             hit
);
    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (flush) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    assign hit = valid_q[rd_idx] && (tag_q[rd_idx] == rd_tag);

    // R4
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ($countones(valid_q) == 0));

    // R8
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !wr_en) |=> $stable(valid_q));

endmodule

// File: rtl/pfc_data_array.sv
module pfc_data_array #(
    parameter int LINES = 64,
    parameter int IDX_W = 6,
    parameter int PKT_W = 256
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PKT_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [PKT_W-1:0] rd_data
);
    logic [PKT_W-1:0] line_q [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                line_q[i] <= wr_data;
            end
        end
    end

    assign rd_data = line_q[rd_idx];

endmodule

// File: rtl/pfc_top.sv
module pfc_top
    import pfc_pkg::*;
#(
    parameter int              ADDR_W    = 32,
    parameter int              PKT_W     = 256,
    parameter int              LINES     = 64,
    parameter logic [ADDR_W-1:0] MAP_BASE0 = 32'h0000_0000,
    parameter logic [ADDR_W-1:0] MAP_BASE1 = 32'h0001_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_in,
    input  logic              map_sel,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_stall,
    output logic              fetch_valid,
    output logic [PKT_W-1:0]  fetch_data,
    output logic              ext_req,
    output logic [ADDR_W-1:0] ext_addr,
    input  logic              ext_ack,
    input  logic [PKT_W-1:0]  ext_data
);
    localparam int PKT_BYTES = PKT_W / 8;
    localparam int OFF_W     = $clog2(PKT_BYTES);
    localparam int IDX_W     = $clog2(LINES);
    localparam int TAG_W     = ADDR_W - IDX_W - OFF_W;

    pfc_state_e        state_q, state_d;
    pfc_mode_e         cur_mode_q;
    pfc_mode_e         req_mode;
    logic [ADDR_W-1:0] pend_addr_q;
    logic              out_valid_q;
    logic [PKT_W-1:0]  out_data_q;

    logic              accept;
    logic              hit;
    logic              flush;
    logic              fill_we;
    logic              in_win;
    logic [IDX_W-1:0]  win_idx;
    logic [IDX_W-1:0]  addr_idx;
    logic [TAG_W-1:0]  addr_tag;
    logic [IDX_W-1:0]  arr_rd_idx;
    logic [PKT_W-1:0]  arr_rd_data;
    logic [IDX_W-1:0]  pend_idx;
    logic [TAG_W-1:0]  pend_tag;

    assign req_mode = pfc_mode_e'(mode_in);
    assign accept   = (state_q == ST_IDLE) && fetch_req;
    assign addr_idx = fetch_addr[OFF_W +: IDX_W];
    assign addr_tag = fetch_addr[ADDR_W-1 -: TAG_W];
    assign pend_idx = pend_addr_q[OFF_W +: IDX_W];
    assign pend_tag = pend_addr_q[ADDR_W-1 -: TAG_W];

    // The only invalidation: a mapped-to-enable change sampled while idle.
    assign flush   = (state_q == ST_IDLE) && (cur_mode_q == MODE_MAPPED)
                     && (req_mode == MODE_ENABLE);
    assign fill_we = (state_q == ST_FILL) && ext_ack;

    assign arr_rd_idx = (cur_mode_q == MODE_MAPPED) ? win_idx : addr_idx;

    pfc_map_window #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .IDX_W  (IDX_W),
        .BASE0  (MAP_BASE0),
        .BASE1  (MAP_BASE1)
    ) u_window (
        .addr    (fetch_addr),
        .map_sel (map_sel),
        .in_win  (in_win),
        .win_idx (win_idx)
    );

    pfc_tag_store #(
        .LINES (LINES),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .wr_en  (fill_we),
        .wr_idx (pend_idx),
        .wr_tag (pend_tag),
        .rd_idx (addr_idx),
        .rd_tag (addr_tag),
        .hit    (hit)
    );

    pfc_data_array #(
        .LINES (LINES),
        .IDX_W (IDX_W),
        .PKT_W (PKT_W)
    ) u_array (
        .clk     (clk),
        .wr_en   (fill_we),
        .wr_idx  (pend_idx),
        .wr_data (ext_data),
        .rd_idx  (arr_rd_idx),
        .rd_data (arr_rd_data)
    );

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    unique case (cur_mode_q)
                        MODE_MAPPED: state_d = ST_IDLE;
                        MODE_ENABLE: state_d = hit ? ST_IDLE : ST_FILL;
                        MODE_FREEZE: state_d = hit ? ST_IDLE : ST_PASS;
                        MODE_BYPASS: state_d = ST_PASS;
                        default:     state_d = ST_IDLE;
                    endcase
                end
            end
            ST_FILL, ST_PASS: begin
                if (ext_ack) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, mode and pending address registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cur_mode_q  <= MODE_MAPPED;
            pend_addr_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE) begin
                cur_mode_q <= req_mode;
            end
            if (accept) begin
                pend_addr_q <= {fetch_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            end
        end
    end

    // Returned data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid_q <= 1'b0;
            out_data_q  <= '0;
        end else begin
            out_valid_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (cur_mode_q == MODE_MAPPED) begin
                            out_valid_q <= 1'b1;
                            out_data_q  <= in_win ? arr_rd_data : '0;
                        end else if (hit && (cur_mode_q != MODE_BYPASS)) begin
                            out_valid_q <= 1'b1;
                            out_data_q  <= arr_rd_data;
                        end
                    end
                end
                ST_FILL, ST_PASS: begin
                    if (ext_ack) begin
                        out_valid_q <= 1'b1;
                        out_data_q  <= ext_data;
                    end
                end
                default: out_valid_q <= 1'b0;
            endcase
        end
    end

    assign fetch_valid = out_valid_q;
    assign fetch_data  = out_data_q;
    assign fetch_stall = (state_q != ST_IDLE);
    assign ext_req     = (state_q != ST_IDLE);
    assign ext_addr    = pend_addr_q;

    // R5
    ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && !ext_ack) |=> (ext_req && $stable(ext_addr)));

    // R5
    ext_forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && ext_ack) |=> (fetch_valid && (fetch_data == $past(ext_data))));

    // R2
    mapped_nostall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_stall && (cur_mode_q == MODE_MAPPED))
            |=> (fetch_valid && !fetch_stall));

    // R8
    bypass_external_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_stall && (cur_mode_q == MODE_BYPASS))
            |=> (ext_req && fetch_stall));

    // R9
    mode_deferred_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_stall |=> (cur_mode_q == $past(cur_mode_q)));

endmodule

// File: tb/tb_pfc_top.sv
module tb_pfc_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode_in = 2'b00;
    logic         map_sel = 1'b0;
    logic         fetch_req = 1'b0;
    logic [31:0]  fetch_addr = '0;
    logic         fetch_stall;
    logic         fetch_valid;
    logic [255:0] fetch_data;
    logic         ext_req;
    logic [31:0]  ext_addr;
    logic         ext_ack = 1'b0;
    logic [255:0] ext_data = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int ext_cnt  = 0;
    int ext_lat  = 2;
    int wcnt     = 0;
    int mem_ver  = 0;
    logic [31:0] last_ext_addr = '0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pfc_top dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_in     (mode_in),
        .map_sel     (map_sel),
        .fetch_req   (fetch_req),
        .fetch_addr  (fetch_addr),
        .fetch_stall (fetch_stall),
        .fetch_valid (fetch_valid),
        .fetch_data  (fetch_data),
        .ext_req     (ext_req),
        .ext_addr    (ext_addr),
        .ext_ack     (ext_ack),
        .ext_data    (ext_data)
    );

    function automatic logic [255:0] pat(logic [31:0] a, int v);
        logic [255:0] r;
        for (int k = 0; k < 8; k++) begin
            r[k*32 +: 32] = a ^ (32'(v) << 20) ^ (32'(k) * 32'h1111_1111);
        end
        return r;
    endfunction

    // External memory model, driven away from the active edge
    always @(negedge clk) begin
        if (ext_ack) begin
            ext_ack = 1'b0;
            wcnt    = 0;
        end else if (ext_req) begin
            if (wcnt >= ext_lat) begin
                ext_ack       = 1'b1;
                ext_data      = pat(ext_addr, mem_ver);
                last_ext_addr = ext_addr;
                ext_cnt++;
            end else begin
                wcnt++;
            end
        end
    end

    task automatic check(bit ok, string req, string what, logic [255:0] act, logic [255:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic set_mode(logic [1:0] m);
        @(negedge clk);
        mode_in = m;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_fetch(logic [31:0] addr, logic [255:0] exp, int exp_ext, string req);
        int e0;
        int lat;
        bit st;
        @(negedge clk);
        e0         = ext_cnt;
        fetch_req  = 1'b1;
        fetch_addr = addr;
        @(negedge clk);
        fetch_req = 1'b0;
        st  = fetch_stall;
        lat = 1;
        while (!fetch_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        check(fetch_valid == 1'b1, req, "valid", 256'(fetch_valid), 256'(1));
        check(fetch_data == exp, req, "data", fetch_data, exp);
        check((ext_cnt - e0) == exp_ext, req, "external reads", 256'(ext_cnt - e0), 256'(exp_ext));
        if (exp_ext == 0) begin
            check(lat == 1, req, "hit latency", 256'(lat), 256'(1));
        end else begin
            check(st == 1'b1, req, "stall during read", 256'(st), 256'(1));
            check(last_ext_addr == {addr[31:5], 5'b0}, req, "aligned address",
                  256'(last_ext_addr), 256'({addr[31:5], 5'b0}));
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        check(fetch_valid == 1'b0 && fetch_stall == 1'b0 && ext_req == 1'b0, "R1",
              "idle outputs", 256'({fetch_valid, fetch_stall, ext_req}), 256'(0));
    endtask

    task automatic test_enable_fill();
        set_mode(2'b01);
        mem_ver = 1;
        // R4 R5: first fetch after enabling misses; offset bits dropped
        do_fetch(32'h0000_004C, pat(32'h40, 1), 1, "R5");
        // R6: same packet now hits
        do_fetch(32'h0000_0044, pat(32'h40, 1), 0, "R6");
    endtask

    task automatic test_freeze();
        set_mode(2'b10);
        mem_ver = 2;
        do_fetch(32'h0000_0040, pat(32'h40, 1), 0, "R7");
        // 0x840 shares index 2 with 0x40 but has another tag
        do_fetch(32'h0000_0840, pat(32'h840, 2), 1, "R7");
        do_fetch(32'h0000_0840, pat(32'h840, 2), 1, "R7");
        do_fetch(32'h0000_0040, pat(32'h40, 1), 0, "R7");
    endtask

    task automatic test_bypass_then_enable();
        set_mode(2'b11);
        mem_ver = 3;
        do_fetch(32'h0000_0040, pat(32'h40, 3), 1, "R8");
        set_mode(2'b01);
        // R10: no flush from bypass, cached copy still version 1
        do_fetch(32'h0000_0040, pat(32'h40, 1), 0, "R10");
    endtask

    task automatic test_mapped();
        set_mode(2'b00);
        map_sel = 1'b0;
        do_fetch(32'h0000_0040, pat(32'h40, 1), 0, "R2");
        map_sel = 1'b1;
        do_fetch(32'h0001_0040, pat(32'h40, 1), 0, "R3");
        do_fetch(32'h0000_0040, '0, 0, "R3");
        map_sel = 1'b0;
        do_fetch(32'h0000_0800, '0, 0, "R3");
    endtask

    task automatic test_flush();
        // fetch accepted on the same edge that samples enable: still mapped
        @(negedge clk);
        mode_in    = 2'b01;
        fetch_req  = 1'b1;
        fetch_addr = 32'h0000_0040;
        @(negedge clk);
        fetch_req = 1'b0;
        check(fetch_valid && fetch_data == pat(32'h40, 1), "R4", "same-edge mapped fetch",
              fetch_data, pat(32'h40, 1));
        repeat (2) @(negedge clk);
        do_fetch(32'h0000_0040, pat(32'h40, 3), 1, "R4");
        do_fetch(32'h0000_0040, pat(32'h40, 3), 0, "R4");
    endtask

    task automatic test_deferral();
        int lat;
        mem_ver = 4;
        ext_lat = 6;
        @(negedge clk);
        fetch_req  = 1'b1;
        fetch_addr = 32'h0000_0080;
        @(negedge clk);
        fetch_req = 1'b0;
        mode_in   = 2'b11;
        lat = 1;
        while (!fetch_valid && lat < 200) begin
            @(negedge clk);
            lat++;
        end
        check(fetch_data == pat(32'h80, 4), "R9", "deferred fill data", fetch_data, pat(32'h80, 4));
        ext_lat = 2;
        mem_ver = 5;
        repeat (2) @(negedge clk);
        do_fetch(32'h0000_0080, pat(32'h80, 5), 1, "R9");
        set_mode(2'b01);
        do_fetch(32'h0000_0080, pat(32'h80, 4), 0, "R9");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_enable_fill();
        test_freeze();
        test_bypass_then_enable();
        test_mapped();
        test_flush();
        test_deferral();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

endmodule